// File: doc/BRIEF.md
# Second-Order Recursive Filter Datapath

This block is a two-pole, two-zero recursive filter section that runs on its own DSP clock. Each accepted input sample is combined with the two previous inputs and the two previous outputs, each weighted by one of five coefficients that arrive on parallel input ports. The weighted sum is brought back to the sample format, clipped to the representable range, registered as the new output, and fed back into the recursion.

Samples are signed fractions: the top bit is the sign and the next bit is worth one half. Coefficients are signed with one integer bit, so they can span from -2.0 up to just below +2.0. The recursion moves forward only on clock edges where the valid strobe is high. A system with slow, multi-cycle multipliers can therefore present a sample every Nth clock and read the result at that same cadence. Several sections can be chained to build higher-order low-pass, high-pass, band-pass or band-stop responses.

Top module: `biquad_iir`

## Requirements
- R1: On an accepted sample the new output is y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] + a1·y[n-1] + a2·y[n-2]. The feedback terms are added, not subtracted, and the coefficient values in use are those present at the accepting edge.
- R2: Samples are DATA_W-bit two's complement with weight 2^-(DATA_W-1) per LSB. Coefficients are COEF_W-bit two's complement with weight 2^-(COEF_W-2) per LSB, so the integer code 2^(COEF_W-2) means 1.0. The full-precision sum is realigned by an arithmetic right shift of COEF_W-2 bits, which rounds toward minus infinity. A coefficient of 1.0 on b0 alone therefore passes every input unchanged, and 0.5 yields floor(x/2).
- R3: If the realigned sum exceeds the DATA_W range, the stored output and feedback value is the most positive code (2^(DATA_W-1)-1) or the most negative code (-2^(DATA_W-1)).
- R4: On edges where valid_in is low, the output, both delayed inputs and both delayed outputs keep their values, whatever x_in and the coefficients do. Later accepted samples see exactly the state left by the last accepted one.
- R5: y_valid is high for the one clock after each edge that accepts a sample, and low after every edge where valid_in is low. y_out carries the new result during that clock.
- R6: An active-low asynchronous reset forces y_out to zero and y_valid low at once, without waiting for a clock, and clears the delay-line state. The first sample after release is filtered from zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DSP clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Accept x_in on this rising edge |
| x_in | input | DATA_W | Input sample, signed fraction |
| coef_b0 | input | COEF_W | Weight of the current input |
| coef_b1 | input | COEF_W | Weight of the input one sample back |
| coef_b2 | input | COEF_W | Weight of the input two samples back |
| coef_a1 | input | COEF_W | Weight of the output one sample back |
| coef_a2 | input | COEF_W | Weight of the output two samples back |
| y_out | output | DATA_W | Filtered sample, signed fraction |
| y_valid | output | 1 | y_out holds a fresh result |

## Verification
The bench builds the filter with DATA_W = 8 and COEF_W = 6, so 1.0 is the coefficient code 16 and every one of the 256 input codes can be swept in turn. It sweeps the whole input range through unity and half-gain pass-through to cover the realignment and its rounding toward minus infinity. It drives full-scale inputs with large gains to reach both saturation limits, and runs an impulse through a feedback-heavy setting. It then runs several thousand pseudo-random samples with random coefficients and random valid gaps against an integer model of the equation, and finishes with an asynchronous reset in the middle of a run.

// File: rtl/biquad_pkg.sv
`timescale 1ns/1ps
package biquad_pkg;
    // Number of weighted terms in the second-order recursion.
    localparam int NUM_TAPS   = 5;
    // Headroom above a single product: five terms need three extra bits.
    localparam int GUARD_BITS = 3;

    // Position of each term in the tap arrays.
    typedef enum logic [2:0] {
        TAP_B0 = 3'd0,
        TAP_B1 = 3'd1,
        TAP_B2 = 3'd2,
        TAP_A1 = 3'd3,
        TAP_A2 = 3'd4
    } tap_e;
endpackage

// File: rtl/biquad_mac.sv
`timescale 1ns/1ps
module biquad_mac
    import biquad_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int ACC_W  = PROD_W + GUARD_BITS
) (
    input  logic signed [DATA_W-1:0] smp  [NUM_TAPS],
    input  logic signed [COEF_W-1:0] coef [NUM_TAPS],
    output logic signed [ACC_W-1:0]  acc
);
    logic signed [PROD_W-1:0] prod [NUM_TAPS];

    // One full-precision multiplier per term.
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        assign prod[t] = PROD_W'(smp[t]) * PROD_W'(coef[t]);
    end

    // Sign-extended sum; guard bits make overflow impossible here.
    always_comb begin
        acc = '0;
        for (int t = 0; t < NUM_TAPS; t++) begin
            acc = acc + ACC_W'(prod[t]);
        end
    end
endmodule

// File: rtl/biquad_sat.sv
`timescale 1ns/1ps
module biquad_sat #(
    parameter int ACC_W  = 35,
    parameter int DATA_W = 16,
    parameter int SHIFT  = 14
) (
    input  logic signed [ACC_W-1:0]  acc,
    output logic signed [DATA_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] MAX_A =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_A =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] aligned;

    // Arithmetic shift drops the extra fractional bits (floor rounding).
    assign aligned = acc >>> SHIFT;

    always_comb begin
        if (aligned > MAX_A) begin
            y = {1'b0, {(DATA_W-1){1'b1}}};
        end else if (aligned < MIN_A) begin
            y = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            y = aligned[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/biquad_iir.sv
`timescale 1ns/1ps
module biquad_iir
    import biquad_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [COEF_W-1:0] coef_b0,
    input  logic signed [COEF_W-1:0] coef_b1,
    input  logic signed [COEF_W-1:0] coef_b2,
    input  logic signed [COEF_W-1:0] coef_a1,
    input  logic signed [COEF_W-1:0] coef_a2,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     y_valid
);
    localparam int ACC_W = DATA_W + COEF_W + GUARD_BITS;
    // One integer bit in the coefficient format leaves COEF_W-2 fraction bits.
    localparam int SHIFT = COEF_W - 2;

    typedef struct packed {
        logic signed [DATA_W-1:0] x1;
        logic signed [DATA_W-1:0] x2;
        logic signed [DATA_W-1:0] y1;
        logic signed [DATA_W-1:0] y2;
        logic                     vld;
    } state_t;

    state_t cur_q, nxt_d;

    logic signed [DATA_W-1:0] tap_smp  [NUM_TAPS];
    logic signed [COEF_W-1:0] tap_coef [NUM_TAPS];
    logic signed [ACC_W-1:0]  acc_w;
    logic signed [DATA_W-1:0] y_new;

    assign tap_smp[int'(TAP_B0)]  = x_in;
    assign tap_smp[int'(TAP_B1)]  = cur_q.x1;
    assign tap_smp[int'(TAP_B2)]  = cur_q.x2;
    assign tap_smp[int'(TAP_A1)]  = cur_q.y1;
    assign tap_smp[int'(TAP_A2)]  = cur_q.y2;
    assign tap_coef[int'(TAP_B0)] = coef_b0;
    assign tap_coef[int'(TAP_B1)] = coef_b1;
    assign tap_coef[int'(TAP_B2)] = coef_b2;
    assign tap_coef[int'(TAP_A1)] = coef_a1;
    assign tap_coef[int'(TAP_A2)] = coef_a2;

    biquad_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) i_mac (
        .smp  (tap_smp),
        .coef (tap_coef),
        .acc  (acc_w)
    );

    biquad_sat #(
        .ACC_W  (ACC_W),
        .DATA_W (DATA_W),
        .SHIFT  (SHIFT)
    ) i_sat (
        .acc (acc_w),
        .y   (y_new)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = valid_in;
        if (valid_in) begin
            nxt_d.x1 = x_in;
            nxt_d.x2 = cur_q.x1;
            nxt_d.y1 = y_new;
            nxt_d.y2 = cur_q.y1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign y_out   = cur_q.y1;
    assign y_valid = cur_q.vld;
endmodule

// File: rtl/biquad_iir_chk.sv
`timescale 1ns/1ps
module biquad_iir_chk
    import biquad_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    localparam int ACC_W = DATA_W + COEF_W + GUARD_BITS,
    localparam int SHIFT = COEF_W - 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     valid_in,
    input logic signed [DATA_W-1:0] x_in,
    input logic signed [DATA_W-1:0] y_out,
    input logic                     y_valid,
    input logic signed [ACC_W-1:0]  acc,
    input logic signed [DATA_W-1:0] x1,
    input logic signed [DATA_W-1:0] y2
);
    localparam logic signed [ACC_W-1:0] MAX_A =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_A =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MAX_Y = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MIN_Y = {1'b1, {(DATA_W-1){1'b0}}};

    AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ((acc >>> SHIFT) > MAX_A)) |=> (y_out == MAX_Y)); // R3
    AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ((acc >>> SHIFT) < MIN_A)) |=> (y_out == MIN_Y)); // R3
    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(y_out)); // R4
    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(x1) && $stable(y2))); // R4
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> ((x1 == $past(x_in)) && (y2 == $past(y_out)))); // R1
    AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> y_valid); // R5
    AST_VLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !y_valid); // R5

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RST_CLEAR: assert (y_out == '0 && !y_valid && x1 == '0 && y2 == '0); // R6
        end
    end
endmodule

bind biquad_iir biquad_iir_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .x_in     (x_in),
    .y_out    (y_out),
    .y_valid  (y_valid),
    .acc      (acc_w),
    .x1       (cur_q.x1),
    .y2       (cur_q.y2)
);

// File: tb/test_biquad_iir.sv
`timescale 1ns/1ps
module test_biquad_iir;
    localparam int DW    = 8;
    localparam int CW    = 6;
    localparam int SH    = CW - 2;
    localparam int Y_MAX = (1 << (DW - 1)) - 1;
    localparam int Y_MIN = -(1 << (DW - 1));
    localparam int C_MIN = -(1 << (CW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_in = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic signed [CW-1:0] cb0 = '0, cb1 = '0, cb2 = '0, ca1 = '0, ca2 = '0;
    logic signed [DW-1:0] y_out;
    logic y_valid;

    int n_chk = 0;
    int n_bad = 0;
    int mx1, mx2, my1, my2;
    int last_y = 0;
    int unsigned seed = 32'h1234_5678;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    biquad_iir #(.DATA_W(DW), .COEF_W(CW)) i_biquad_iir (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_in (valid_in),
        .x_in     (x_in),
        .coef_b0  (cb0),
        .coef_b1  (cb1),
        .coef_b2  (cb2),
        .coef_a1  (ca1),
        .coef_a2  (ca2),
        .y_out    (y_out),
        .y_valid  (y_valid)
    );

    function automatic int unsigned lcg();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic model_clear();
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    // Integer model of the requirements: sum, floor shift, clip, shift state.
    function automatic int model_step(int x);
        int acc, al, y;
        acc = int'(cb0) * x + int'(cb1) * mx1 + int'(cb2) * mx2
            + int'(ca1) * my1 + int'(ca2) * my2;
        al = acc >>> SH;
        y  = (al > Y_MAX) ? Y_MAX : ((al < Y_MIN) ? Y_MIN : al);
        mx2 = mx1; mx1 = x; my2 = my1; my1 = y;
        return y;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_coef(int b0, int b1, int b2, int a1, int a2);
        cb0 = b0[CW-1:0]; cb1 = b1[CW-1:0]; cb2 = b2[CW-1:0];
        ca1 = a1[CW-1:0]; ca2 = a2[CW-1:0];
    endtask

    // Starts at a falling edge, spans one rising edge, samples at the next falling edge.
    task automatic cycle(int x, bit v, string req);
        int e;
        x_in = x[DW-1:0];
        valid_in = v;
        @(negedge clk);
        check("R5", "y_valid", int'(y_valid), int'(v));
        if (v) begin
            e = model_step(x);
            check(req, "y_out", int'(y_out), e);
        end else begin
            check("R4", "held y_out", int'(y_out), last_y);
        end
        last_y = int'(y_out);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        @(negedge clk);
        @(negedge clk);
        check("R6", "reset y_out", int'(y_out), 0);
        check("R6", "reset y_valid", int'(y_valid), 0);
        rst_n = 1'b1;
        model_clear();
        last_y = 0;

        // R1: impulse response with feedback (1.0, 0.5, 0.25 ; 0.5, -0.25)
        set_coef(16, 8, 4, 8, -4);
        cycle(64, 1'b1, "R1");
        for (int i = 0; i < 24; i++) cycle(0, 1'b1, "R1");
        // R1: impulse through resonant feedback (a1 = 1.5, a2 = -0.75)
        set_coef(16, 0, 0, 24, -12);
        cycle(-100, 1'b1, "R1");
        for (int i = 0; i < 40; i++) cycle(0, 1'b1, "R1");

        // R2: unity pass-through over every input code
        set_coef(16, 0, 0, 0, 0);
        for (int x = Y_MIN; x <= Y_MAX; x++) cycle(x, 1'b1, "R2");
        // R2: half gain, floor rounding for odd negative codes
        set_coef(8, 0, 0, 0, 0);
        for (int x = Y_MIN; x <= Y_MAX; x++) cycle(x, 1'b1, "R2");
        // R2: most negative coefficient (-2.0) on the oldest input
        set_coef(0, 0, C_MIN, 0, 0);
        for (int x = Y_MIN; x <= Y_MAX; x++) cycle(x, 1'b1, "R2");

        // R3: large gains drive both limits
        set_coef(31, 31, 31, 31, 0);
        for (int i = 0; i < 12; i++) cycle(Y_MAX, 1'b1, "R3");
        for (int i = 0; i < 12; i++) cycle(Y_MIN, 1'b1, "R3");
        for (int x = Y_MIN; x <= Y_MAX; x++) cycle(x, 1'b1, "R3");

        // R4: random coefficients, random gaps with scrambled idle inputs
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = lcg();
            if (i % 64 == 0) begin
                set_coef(int'($signed(r[5:0])), int'($signed(r[11:6])),
                         int'($signed(r[17:12])), int'($signed(r[23:18])),
                         int'($signed(r[29:24])) >>> 1);
            end
            r = lcg();
            cycle(int'($signed(r[7:0])), r[9:8] != 2'b00, "R4");
            if (r[9:8] == 2'b00) begin
                cb0 = r[15:10];
            end
        end

        // R6: asynchronous reset mid-run
        set_coef(12, -8, 5, 20, -9);
        for (int i = 0; i < 10; i++) cycle(90 - 17 * i, 1'b1, "R6");
        valid_in = 1'b0;
        #1 rst_n = 1'b0;
        #1;
        check("R6", "async y_out", int'(y_out), 0);
        check("R6", "async y_valid", int'(y_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        last_y = 0;
        for (int i = 0; i < 10; i++) cycle(55 - 11 * i, 1'b1, "R6");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule